// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep and Wake

This block takes an asynchronous serial line sampled once per `sample_tick` (sixteen ticks per bit time) and turns each character into a parallel word with status. A start bit is only accepted after the line has been high for at least three samples. The low that follows is then confirmed by a vote of three samples. Each data bit and the stop bit is also decided by a three-sample vote taken around the middle of its bit time. Any disagreement among the three votes of a data bit or of the stop bit is reported as noise.

The received word leaves on a valid/ready output. `out_valid` rises with the word and its flags (framing, parity, noise). The word stays frozen until the handshake `out_valid && out_ready` takes it. While the word is waiting, a newly finished character is dropped and `err_overrun` is raised in its place, so the consumer applies back-pressure simply by holding `out_ready` low.

A sleep mode lets a receiver on a shared line ignore traffic. Sleep ends either on an idle line or on a character whose last data bit is set, depending on the configuration. Idle detection also maintains a receiver-active indication.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `out_valid`, `rx_data`, all error flags, `idle_flag`, `rx_active` and `rx_asleep` are 0.
- R2: A start bit is taken only after at least three consecutive high samples followed by a low sample (sample 1). Samples 3, 5 and 7 are then voted, and at least two of them must be low. If the vote fails, the receiver returns to hunting, clears `rx_active` and reports nothing.
- R3: Each data bit is the majority of samples 8, 9 and 10 of its bit time. Bits arrive LSB first, and data bit k lands in `rx_data[k]`.
- R4: `cfg_nine`=0 gives 8 data bits with `rx_data[8]`=0. `cfg_nine`=1 gives 9 data bits. One stop bit follows the data bits.
- R5: With `cfg_par_en`=1, the last data bit is a parity bit. `err_parity` is 1 when the count of ones among all data bits is odd (`cfg_par_odd`=0) or even (`cfg_par_odd`=1). With `cfg_par_en`=0, `err_parity` is 0.
- R6: `err_frame` is 1 when the vote on the stop bit is 0.
- R7: `err_noise` is 1 when the three votes of any data bit or of the stop bit differ. It is loaded together with the word.
- R8: If a character completes while `out_valid` is 1 and no handshake happens in that cycle, the character is dropped: `err_overrun` rises, while `rx_data`, `err_noise` and the other frame flags keep their values.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `rx_data` hold. A handshake clears `out_valid` and `err_overrun` on the next edge.
- R10: `rx_active` rises on an accepted start-bit low sample. It clears when an idle character is detected.
- R11: Idle detection is armed by a start bit. It fires after 16x(data bits+2) consecutive high samples. With `cfg_idle_after_stop`=0, counting starts after the start bit. With `cfg_idle_after_stop`=1, counting starts after the stop decision. Firing sets `idle_flag`, and the next start bit clears it.
- R12: A `wake_arm` pulse sets `rx_asleep`. While asleep, characters raise neither `out_valid` nor any flag, and an idle detection does not set `idle_flag`. With `cfg_wake_addr`=0, an idle detection clears `rx_asleep`.
- R13: With `cfg_wake_addr`=1, a character whose last data bit is 1 clears `rx_asleep` and is delivered. Other characters are dropped while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | One pulse per sample, 16 per bit |
| rx_line | input | 1 | Serial line, synchronous to clk |
| cfg_nine | input | 1 | 1 = nine data bits |
| cfg_par_en | input | 1 | Last data bit is parity |
| cfg_par_odd | input | 1 | 1 = odd parity |
| cfg_wake_addr | input | 1 | 1 = wake on last data bit set, 0 = wake on idle |
| cfg_idle_after_stop | input | 1 | Idle count starts after stop (1) or after start (0) |
| wake_arm | input | 1 | Pulse: enter sleep |
| out_ready | input | 1 | Consumer accepts the word |
| out_valid | output | 1 | Word and frame flags are valid |
| rx_data | output | 9 | Received data bits |
| err_overrun | output | 1 | A character was dropped while the word waited |
| err_noise | output | 1 | Vote disagreement in the word |
| err_frame | output | 1 | Stop bit read as 0 |
| err_parity | output | 1 | Parity mismatch |
| idle_flag | output | 1 | Idle character seen |
| rx_active | output | 1 | Reception in progress |
| rx_asleep | output | 1 | Sleep mode |

## Verification
The word and its flags are registered on the clock edge that carries the tenth sample of the stop bit. The bench therefore checks them only after the whole stop bit plus four idle samples, so the result is settled and no later character can touch it. Idle detection is due a fixed number of samples after the stop decision (ILT=1) or after the start bit (ILT=0). The bench probes one point where only one of the two settings can have fired, then a later point where both must have fired. Handshake effects are checked on the falling edge after the one-cycle `out_ready` pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR  = 16;
  localparam int DMAX = 9;

  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_BITS} rx_state_e;

  typedef struct packed {
    logic [DMAX-1:0] data;
    logic            ferr;
    logic            perr;
    logic            noise;
    logic            mark;
  } rx_frame_t;
endpackage

// File: rtl/uart_rx_vote3.sv
module uart_rx_vote3 (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic rx,
  output logic maj,
  output logic clean
);
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist <= 2'b00;
    else if (cap) hist <= {hist[0], rx};
  end

  // third vote is the live sample at the decision tick
  assign maj   = (hist[1] & hist[0]) | (hist[1] & rx) | (hist[0] & rx);
  assign clean = (hist[1] == hist[0]) && (hist[0] == rx);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic      cfg_nine,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  output logic      start_seen,
  output logic      false_start,
  output logic      frame_done,
  output logic      in_start,
  output logic      busy,
  output rx_frame_t result
);
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(DMAX + 1);
  localparam logic [SW-1:0] S_V0   = SW'(OSR / 8);
  localparam logic [SW-1:0] S_V1   = SW'(OSR / 4);
  localparam logic [SW-1:0] S_V2   = SW'(3 * OSR / 8);
  localparam logic [SW-1:0] D_V0   = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] D_V1   = SW'(OSR / 2);
  localparam logic [SW-1:0] D_V2   = SW'(OSR / 2 + 1);
  localparam logic [SW-1:0] S_LAST = SW'(OSR - 1);

  rx_state_e       state;
  logic [SW-1:0]   samp;
  logic [BW-1:0]   bitidx;
  logic [BW-1:0]   nbits;
  logic [1:0]      ones;
  logic [DMAX-1:0] shreg;
  logic            nacc;
  logic            cap, maj, clean, s_dec, d_dec;

  assign nbits = cfg_nine ? BW'(DMAX) : BW'(DMAX - 1);
  assign s_dec = tick && (state == RX_START) && (samp == S_V2);
  assign d_dec = tick && (state == RX_BITS) && (samp == D_V2);
  assign cap   = tick && (((state == RX_START) && (samp == S_V0 || samp == S_V1)) ||
                          ((state == RX_BITS)  && (samp == D_V0 || samp == D_V1)));

  uart_rx_vote3 u_vote (.clk(clk), .rst_n(rst_n), .cap(cap), .rx(rx), .maj(maj), .clean(clean));

  assign start_seen  = tick && (state == RX_HUNT) && !rx && (ones == 2'd3);
  assign false_start = s_dec && maj;
  assign frame_done  = d_dec && (bitidx == nbits);
  assign in_start    = (state == RX_START);
  assign busy        = (state != RX_HUNT);

  assign result.data  = shreg;
  assign result.ferr  = !maj;
  assign result.perr  = cfg_par_en && ((^shreg) ^ cfg_par_odd);
  assign result.noise = nacc | !clean;
  assign result.mark  = cfg_nine ? shreg[DMAX-1] : shreg[DMAX-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_HUNT;
      samp   <= '0;
      bitidx <= '0;
      ones   <= 2'd0;
      shreg  <= '0;
      nacc   <= 1'b0;
    end else if (tick) begin
      case (state)
        RX_HUNT: begin
          if (start_seen) begin
            state <= RX_START;
            samp  <= SW'(1);
          end else begin
            ones <= rx ? ((ones == 2'd3) ? 2'd3 : ones + 2'd1) : 2'd0;
          end
        end
        RX_START: begin
          if (false_start) begin
            state <= RX_HUNT;
            ones  <= 2'd0;
          end else if (samp == S_LAST) begin
            state  <= RX_BITS;
            samp   <= '0;
            bitidx <= '0;
            shreg  <= '0;
            nacc   <= 1'b0;
          end else begin
            samp <= samp + SW'(1);
          end
        end
        default: begin
          samp <= (samp == S_LAST) ? '0 : samp + SW'(1);
          if (d_dec) begin
            if (bitidx == nbits) begin
              state <= RX_HUNT;
              ones  <= 2'd0;
            end else begin
              shreg[bitidx] <= maj;
              nacc          <= nacc | !clean;
              bitidx        <= bitidx + BW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
  import uart_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic arm,
  input  logic hold,
  input  logic cfg_nine,
  output logic idle_evt
);
  localparam int CW = $clog2(OSR * (DMAX + 2) + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thresh;
  logic          armed;

  assign thresh   = cfg_nine ? CW'(OSR * (DMAX + 2)) : CW'(OSR * (DMAX + 1));
  assign idle_evt = tick && armed && rx && !hold && (cnt == thresh - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (tick) begin
        if (hold || !rx)    cnt <= '0;
        else if (cnt < thresh) cnt <= cnt + CW'(1);
      end
      if (arm)           armed <= 1'b1;
      else if (idle_evt) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_tick,
  input  logic            rx_line,
  input  logic            cfg_nine,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_wake_addr,
  input  logic            cfg_idle_after_stop,
  input  logic            wake_arm,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [DMAX-1:0] rx_data,
  output logic            err_overrun,
  output logic            err_noise,
  output logic            err_frame,
  output logic            err_parity,
  output logic            idle_flag,
  output logic            rx_active,
  output logic            rx_asleep
);
  logic      start_seen, false_start, frame_done, in_start, busy, idle_evt;
  logic      sleeping, hs, deliver, wake_now, mark_hit;
  rx_frame_t res;

  uart_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_line),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .start_seen(start_seen), .false_start(false_start), .frame_done(frame_done),
    .in_start(in_start), .busy(busy), .result(res)
  );

  uart_rx_idle u_idle (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_line), .arm(start_seen),
    .hold(cfg_idle_after_stop ? busy : in_start), .cfg_nine(cfg_nine), .idle_evt(idle_evt)
  );

  assign mark_hit  = cfg_wake_addr && res.mark;
  assign wake_now  = sleeping && ((!cfg_wake_addr && idle_evt) || (frame_done && mark_hit));
  assign deliver   = frame_done && (!sleeping || mark_hit);
  assign hs        = out_valid && out_ready;
  assign rx_asleep = sleeping;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      rx_data     <= '0;
      err_overrun <= 1'b0;
      err_noise   <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      idle_flag   <= 1'b0;
      rx_active   <= 1'b0;
      sleeping    <= 1'b0;
    end else begin
      if (deliver && (!out_valid || hs)) begin
        out_valid   <= 1'b1;
        rx_data     <= res.data;
        err_frame   <= res.ferr;
        err_parity  <= res.perr;
        err_noise   <= res.noise;
        err_overrun <= 1'b0;
      end else if (deliver) begin
        err_overrun <= 1'b1;
      end else if (hs) begin
        out_valid   <= 1'b0;
        err_overrun <= 1'b0;
      end
      sleeping <= wake_arm | (sleeping & !wake_now);
      if (start_seen)                  idle_flag <= 1'b0;
      else if (idle_evt && !sleeping)  idle_flag <= 1'b1;
      if (start_seen)                    rx_active <= 1'b1;
      else if (idle_evt || false_start)  rx_active <= 1'b0;
    end
  end

  // R8
  ovr_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> ($past(out_valid) && $stable(rx_data) && $stable(err_noise)));
  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rx_data)));
  // R11
  idle_not_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> !$past(sleeping));
  // R12
  asleep_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (!$past(sleeping) || $past(cfg_wake_addr)));
  // R10
  active_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(!rx_line));
  // R13
  mark_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleeping) && $past(cfg_wake_addr) && !$past(out_valid)) |-> $rose(out_valid));
endmodule

// File: tb/sim_uart_os_rx.sv
module sim_uart_os_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rx = 1'b1;
  logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic cfg_wake_addr = 1'b0, cfg_ilt = 1'b0, wake_arm = 1'b0, out_ready = 1'b0;
  logic out_valid, err_overrun, err_noise, err_frame, err_parity, idle_flag, rx_active, rx_asleep;
  logic [8:0] rx_data;
  int nchk = 0, nfail = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  uart_os_rx u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .rx_line(rx),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_wake_addr(cfg_wake_addr), .cfg_idle_after_stop(cfg_ilt), .wake_arm(wake_arm),
    .out_ready(out_ready), .out_valid(out_valid), .rx_data(rx_data),
    .err_overrun(err_overrun), .err_noise(err_noise), .err_frame(err_frame),
    .err_parity(err_parity), .idle_flag(idle_flag), .rx_active(rx_active), .rx_asleep(rx_asleep)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic smp(input logic v);
    @(negedge clk); rx = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) smp(1'b1);
  endtask

  task automatic sbit(input logic v, input logic [15:0] g);
    for (int i = 0; i < 16; i++) smp(v ^ g[i]);
  endtask

  task automatic frame(input logic [8:0] w, input int nb, input int gbit,
                       input logic [15:0] g, input logic stopv);
    sbit(1'b0, 16'h0);
    for (int k = 0; k < nb; k++) sbit(w[k], (k == gbit) ? g : 16'h0);
    sbit(stopv, 16'h0);
  endtask

  task automatic ack();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); wake_arm = 1'b1;
    @(negedge clk); wake_arm = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual running expected finished");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", out_valid, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {err_overrun, err_noise, err_frame, err_parity, idle_flag, rx_active, rx_asleep}, 0);
    idle(20);

    // R3 R4 R5 R6 R7 R9 sweep over length and parity settings
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 16; i++) begin
        int nb;
        logic [8:0] w;
        logic ep;
        cfg_nine = c[1]; cfg_par_en = c[0]; cfg_par_odd = i[2];
        nb = cfg_nine ? 9 : 8;
        w = 9'((i * 97 + 13) & ((1 << nb) - 1));
        ep = cfg_par_en & ((^w) ^ cfg_par_odd);
        frame(w, nb, -1, 16'h0, 1'b1);
        idle(4);
        chk("R9 valid after frame", out_valid, 1);
        chk("R3 R4 data", rx_data, w);
        chk("R5 parity", err_parity, ep);
        chk("R6 frame ok", err_frame, 0);
        chk("R7 no noise", err_noise, 0);
        ack();
        chk("R9 valid cleared", out_valid, 0);
      end
    end
    cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0;

    // R7 single glitch on sample 9 of bit 2
    frame(9'h0A5, 8, 2, 16'h0100, 1'b1); idle(4);
    chk("R3 glitched data", rx_data, 9'h0A5);
    chk("R7 noise", err_noise, 1);
    ack();
    // R3 samples 8 and 9 of bit 3 flipped: majority flips the bit
    frame(9'h0A5, 8, 3, 16'h0180, 1'b1); idle(4);
    chk("R3 majority", rx_data, 9'h0AD);
    chk("R7 noise flip", err_noise, 1);
    ack();
    // R6 low stop bit
    frame(9'h03C, 8, -1, 16'h0, 1'b0); idle(4);
    chk("R6 ferr", err_frame, 1);
    chk("R6 data", rx_data, 9'h03C);
    ack();

    // R8 overrun with a noisy second character
    frame(9'h011, 8, -1, 16'h0, 1'b1); idle(4);
    frame(9'h022, 8, 0, 16'h0100, 1'b1); idle(4);
    chk("R8 valid", out_valid, 1);
    chk("R8 overrun", err_overrun, 1);
    chk("R8 kept data", rx_data, 9'h011);
    chk("R8 no noise", err_noise, 0);
    idle(10);
    chk("R9 held", rx_data, 9'h011);
    ack();
    chk("R9 overrun cleared", err_overrun, 0);
    chk("R9 valid clr", out_valid, 0);

    // R2 false start
    idle(4);
    smp(1'b0); smp(1'b0);
    idle(14);
    chk("R2 no word", out_valid, 0);
    chk("R2 active cleared", rx_active, 0);
    frame(9'h05A, 8, -1, 16'h0, 1'b1); idle(4);
    chk("R2 resync valid", out_valid, 1);
    chk("R2 resync data", rx_data, 9'h05A);
    ack();

    // R10 R11 idle after stop
    cfg_ilt = 1;
    frame(9'h0FF, 8, -1, 16'h0, 1'b1);
    chk("R10 active", rx_active, 1);
    idle(100);
    chk("R11 not yet", idle_flag, 0);
    idle(80);
    chk("R11 idle", idle_flag, 1);
    chk("R10 active cleared", rx_active, 0);
    ack();
    // R11 idle counted from start bit
    cfg_ilt = 0;
    frame(9'h0FF, 8, -1, 16'h0, 1'b1);
    idle(100);
    chk("R11 early idle", idle_flag, 1);
    ack();

    // R12 idle wake
    cfg_wake_addr = 0;
    pulse_arm();
    chk("R12 asleep", rx_asleep, 1);
    frame(9'h042, 8, -1, 16'h0, 1'b1); idle(4);
    chk("R12 dropped", out_valid, 0);
    idle(200);
    chk("R12 woke", rx_asleep, 0);
    chk("R12 no idle flag", idle_flag, 0);
    frame(9'h043, 8, -1, 16'h0, 1'b1); idle(4);
    chk("R12 after wake", rx_data, 9'h043);
    ack();

    // R13 address wake
    cfg_wake_addr = 1;
    pulse_arm();
    frame(9'h012, 8, -1, 16'h0, 1'b1); idle(4);
    chk("R13 dropped", out_valid, 0);
    chk("R13 still asleep", rx_asleep, 1);
    frame(9'h085, 8, -1, 16'h0, 1'b1); idle(4);
    chk("R13 delivered", out_valid, 1);
    chk("R13 data", rx_data, 9'h085);
    chk("R13 awake", rx_asleep, 0);
    ack();

    report();
    $finish;
  end
endmodule